// File: doc/BRIEF.md
# Phase-Stepped Interval Measurement Controller

This block measures the delay from a START pulse that it issues itself to a later STOP edge coming from outside. It does this in two passes. In the coarse pass it counts whole periods of the reference clock from START until the synchronized STOP arrives, which gives J. In the fine pass it drives an external variable phase shifter one increment at a time. After each increment it fires START again and a probe clocked by the shifted clock counts its own view of STOP. The pass ends at the first step at which that probe places STOP in the same reference period that the coarse pass found. The step count at that point is K. The interval is then J·Tclk + K·dt, where dt is one phase step: a 256th of the clock period in the default setup.

The shifter interface has three signals: a one-cycle shift strobe, a direction select and a one-cycle done acknowledge. The shifter clock has the same frequency as the reference clock and lags it by the accumulated phase. When the measurement is complete, the block undoes its K increments with K decrements, so the shifter is back at zero phase before the result is declared valid. If STOP does not arrive within a programmable number of whole periods, the block flags overflow and skips the fine pass.

Top module: `ps_tdc_ctrl`

## Requirements
- R1: J equals the number of reference edges after the START edge at which STOP was still low. STOP passes through two synchronizer flops, and those two flops add nothing to J.
- R2: START is high for exactly one reference cycle per run. A measurement issues one START for the coarse pass plus one per fine step, so K+1 in total, or exactly one when it overflows.
- R3: Each fine step holds the shift strobe high for exactly one cycle with the direction select at 1 (increment). No new strobe is issued while an earlier one still waits for its done acknowledge.
- R4: Let φk be the shifter lag after k increments and let frac be the part of the STOP delay beyond J whole periods. K is the smallest k ≥ 1 with φk > frac. This is the first step at which the shifted probe counts J reference periods before STOP.
- R5: If no step up to STEPS−1 (255) meets the R4 condition, K saturates at STEPS−1.
- R6: Before the result is declared valid, the block issues exactly K strobes with the direction select at 0 (decrement), so the shifter's net phase is zero.
- R7: If J would exceed max_coarse, the block sets overflow, reports coarse_j = max_coarse and fine_k = 0, and issues no shift strobe.
- R8: result_valid stays high until the next request is accepted, and falls on the edge that accepts it.
- R9: During reset, start_pulse, ps_en, result_valid, overflow and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| ps_clk | input | 1 | Phase-shifted copy of clk from the shifter |
| meas_req | input | 1 | Starts a measurement when the block is idle and STOP is quiet |
| max_coarse | input | CW | Largest J accepted before overflow |
| stop_in | input | 1 | Asynchronous STOP event |
| ps_done | input | 1 | One-cycle acknowledge from the shifter |
| start_pulse | output | 1 | START pulse issued to the measured path |
| ps_en | output | 1 | One-cycle shift strobe |
| ps_inc | output | 1 | Shift direction: 1 increment, 0 decrement |
| coarse_j | output | CW | Whole reference periods J |
| fine_k | output | log2(STEPS) | Fine step count K |
| overflow | output | 1 | STOP did not arrive within max_coarse periods |
| result_valid | output | 1 | J, K and overflow are valid |
| busy | output | 1 | A measurement is in progress |

## Verification
The bench replaces the shifter with a model that lags ps_clk by 1 ps plus 78 ps per step. It drives STOP delays that place frac just above zero, in the middle of the period and just below a full period, with J at 0, at max_coarse and one above it. A block that compared the shifted count off by one would report K at zero or a whole period too late. A block that mishandled the last step would wrap K instead of holding it at 255. A block that forgot the return pass would leave the model's phase nonzero when result_valid rises, and one that did not skip the fine pass on overflow would show shift strobes and extra START pulses.

// File: rtl/ps_tdc_pkg.sv
`timescale 1ps/1ps
package ps_tdc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_COARSE,
    ST_SHIFT,
    ST_SHIFT_WAIT,
    ST_ARM,
    ST_FINE,
    ST_RET,
    ST_RET_WAIT,
    ST_DONE
  } tdc_state_e;

  // Raw coarse count includes one edge per synchronizer flop.
  function automatic int periods_from_count(int raw, int sync_depth);
    return raw - sync_depth;
  endfunction

  // The shifted probe arms on the edge that sees START, so it counts one
  // edge fewer than the coarse counter when both see STOP in one period.
  function automatic logic same_period(int probe_cnt, int coarse_cnt);
    return (probe_cnt + 1) == coarse_cnt;
  endfunction

endpackage

// File: rtl/ps_tdc_sync.sv
`timescale 1ps/1ps
module ps_tdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ps_tdc_probe.sv
`timescale 1ps/1ps
module ps_tdc_probe #(
  parameter int CNTW = 10,
  parameter int SYNC = 2
) (
  input  logic            ps_clk,
  input  logic            rst_n,
  input  logic            stop_in,
  input  logic            arm_in,
  output logic [CNTW-1:0] cnt_out,
  output logic            done_tgl
);
  logic            stop_s;
  logic            run;
  logic [CNTW-1:0] cnt;

  ps_tdc_sync #(.STAGES(SYNC)) u_stop_sync (
    .clk(ps_clk), .rst_n(rst_n), .d(stop_in), .q(stop_s)
  );

  always_ff @(posedge ps_clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cnt      <= '0;
      cnt_out  <= '0;
      done_tgl <= 1'b0;
    end else if (!run) begin
      if (arm_in) begin
        run <= 1'b1;
        cnt <= '0;
      end
    end else if (stop_s) begin
      run      <= 1'b0;
      cnt_out  <= cnt;
      done_tgl <= ~done_tgl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // A probe run stays armed until the synchronized STOP ends it.
  AST_PROBE_ENDS_ON_STOP: assert property (@(posedge ps_clk) disable iff (!rst_n)
    (run && stop_s) |=> !run);  // R4
endmodule

// File: rtl/ps_tdc_ctrl.sv
`timescale 1ps/1ps
module ps_tdc_ctrl #(
  parameter int CW    = 8,
  parameter int STEPS = 256,
  parameter int SYNC  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ps_clk,
  input  logic                     meas_req,
  input  logic [CW-1:0]            max_coarse,
  input  logic                     stop_in,
  input  logic                     ps_done,
  output logic                     start_pulse,
  output logic                     ps_en,
  output logic                     ps_inc,
  output logic [CW-1:0]            coarse_j,
  output logic [$clog2(STEPS)-1:0] fine_k,
  output logic                     overflow,
  output logic                     result_valid,
  output logic                     busy
);
  import ps_tdc_pkg::*;

  localparam int KW  = $clog2(STEPS);
  localparam int CCW = CW + $clog2(SYNC + 1) + 1;
  localparam logic [KW-1:0] K_LAST = KW'(STEPS - 1);

  tdc_state_e      state;
  logic [CCW-1:0]  cc;
  logic [CCW-1:0]  cc_lat;
  logic [KW-1:0]   k;
  logic            fine_mode;
  logic            stop_s;
  logic            tgl_s, tgl_q;
  logic            probe_tgl;
  logic [CCW-1:0]  probe_cnt;

  // Named internal events
  logic            req_take;
  logic            coarse_limit;
  logic            probe_evt;
  logic            probe_match;

  ps_tdc_sync #(.STAGES(SYNC)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .d(stop_in), .q(stop_s)
  );

  ps_tdc_probe #(.CNTW(CCW), .SYNC(SYNC)) u_probe (
    .ps_clk(ps_clk), .rst_n(rst_n), .stop_in(stop_in),
    .arm_in(start_pulse & fine_mode),
    .cnt_out(probe_cnt), .done_tgl(probe_tgl)
  );

  ps_tdc_sync #(.STAGES(SYNC)) u_tgl_sync (
    .clk(clk), .rst_n(rst_n), .d(probe_tgl), .q(tgl_s)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_s;

  assign req_take     = (state == ST_IDLE) && meas_req && !stop_s;
  assign coarse_limit = cc == (CCW'(max_coarse) + CCW'(SYNC));
  assign probe_evt    = tgl_s ^ tgl_q;
  assign probe_match  = same_period(32'(probe_cnt), 32'(cc_lat));
  assign busy         = state != ST_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cc           <= '0;
      cc_lat       <= '0;
      k            <= '0;
      fine_mode    <= 1'b0;
      start_pulse  <= 1'b0;
      ps_en        <= 1'b0;
      ps_inc       <= 1'b0;
      coarse_j     <= '0;
      fine_k       <= '0;
      overflow     <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      ps_en <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_take) begin
          start_pulse  <= 1'b1;
          cc           <= '0;
          k            <= '0;
          fine_mode    <= 1'b0;
          overflow     <= 1'b0;
          result_valid <= 1'b0;
          state        <= ST_COARSE;
        end
        ST_COARSE: begin
          start_pulse <= 1'b0;
          if (stop_s) begin
            cc_lat    <= cc;
            coarse_j  <= CW'(periods_from_count(32'(cc), SYNC));
            fine_mode <= 1'b1;
            state     <= ST_SHIFT;
          end else if (coarse_limit) begin
            overflow <= 1'b1;
            coarse_j <= max_coarse;
            fine_k   <= '0;
            state    <= ST_DONE;
          end else begin
            cc <= cc + 1'b1;
          end
        end
        ST_SHIFT: begin
          ps_en  <= 1'b1;
          ps_inc <= 1'b1;
          k      <= k + 1'b1;
          state  <= ST_SHIFT_WAIT;
        end
        ST_SHIFT_WAIT: if (ps_done) state <= ST_ARM;
        ST_ARM: if (!stop_s) begin
          start_pulse <= 1'b1;
          state       <= ST_FINE;
        end
        ST_FINE: begin
          start_pulse <= 1'b0;
          if (probe_evt) begin
            if (probe_match || k == K_LAST) begin
              fine_k    <= k;
              fine_mode <= 1'b0;
              state     <= ST_RET;
            end else begin
              state <= ST_SHIFT;
            end
          end
        end
        ST_RET: begin
          if (k == '0) begin
            state <= ST_DONE;
          end else begin
            ps_en  <= 1'b1;
            ps_inc <= 1'b0;
            k      <= k - 1'b1;
            state  <= ST_RET_WAIT;
          end
        end
        ST_RET_WAIT: if (ps_done) state <= ST_RET;
        ST_DONE: begin
          result_valid <= 1'b1;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker-side tracking of the shifter's net phase
  logic                shift_pend;
  logic                pend_dir;
  logic signed [KW+1:0] phase_net;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_pend <= 1'b0;
      pend_dir   <= 1'b0;
      phase_net  <= '0;
    end else if (ps_en) begin
      shift_pend <= 1'b1;
      pend_dir   <= ps_inc;
    end else if (ps_done && shift_pend) begin
      shift_pend <= 1'b0;
      phase_net  <= pend_dir ? phase_net + 1'b1 : phase_net - 1'b1;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);  // R2
  AST_SHIFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |=> !ps_en);  // R3
  AST_SHIFT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |-> !shift_pend);  // R3
  AST_ZERO_PHASE_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> (phase_net == '0));  // R6
  AST_OVF_NO_FINE: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && result_valid) |-> (fine_k == '0));  // R7
  AST_OVF_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !ps_en);  // R7
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !req_take) |=> result_valid);  // R8
endmodule

// File: tb/ps_tdc_ctrl_tb.sv
`timescale 1ps/1ps
module ps_tdc_ctrl_tb;
  localparam int T     = 20000;
  localparam int HALF  = T / 2;
  localparam int DT    = 78;
  localparam int PH0   = 1;
  localparam int CW    = 8;
  localparam int STEPS = 256;
  localparam int KW    = $clog2(STEPS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ps_clk = 1'b0;
  logic          meas_req = 1'b0;
  logic [CW-1:0] max_coarse = '0;
  logic          stop_in = 1'b0;
  logic          ps_done;
  logic          start_pulse, ps_en, ps_inc, overflow, result_valid, busy;
  logic [CW-1:0] coarse_j;
  logic [KW-1:0] fine_k;

  int checks = 0;
  int errors = 0;
  int ph_steps = 0;
  int n_inc = 0, n_dec = 0, n_start = 0;
  int t_stop = 0;
  int lat = 0;
  logic dir = 1'b0;
  logic finished = 1'b0;

  ps_tdc_ctrl #(.CW(CW), .STEPS(STEPS), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ps_clk(ps_clk), .meas_req(meas_req),
    .max_coarse(max_coarse), .stop_in(stop_in), .ps_done(ps_done),
    .start_pulse(start_pulse), .ps_en(ps_en), .ps_inc(ps_inc),
    .coarse_j(coarse_j), .fine_k(fine_k), .overflow(overflow),
    .result_valid(result_valid), .busy(busy)
  );

  always #(HALF) clk = ~clk;

  // Shifted clock: lags clk by PH0 + ph_steps*DT picoseconds.
  always @(posedge clk) begin
    fork
      begin
        automatic int d = PH0 + ph_steps * DT;
        if (d < 0) d = 0;
        #(d) ps_clk = 1'b1;
        #(HALF) ps_clk = 1'b0;
      end
    join_none
  end

  // Shifter model: done three cycles after the strobe.
  always @(posedge clk) begin
    ps_done <= 1'b0;
    if (!rst_n) begin
      lat <= 0;
    end else if (ps_en) begin
      lat <= 3;
      dir <= ps_inc;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        ps_done <= 1'b1;
        if (dir) begin ph_steps <= ph_steps + 1; n_inc <= n_inc + 1; end
        else     begin ph_steps <= ph_steps - 1; n_dec <= n_dec + 1; end
      end
    end
  end

  // STOP follows each START by t_stop and stays high for four periods.
  always @(posedge start_pulse) begin
    n_start = n_start + 1;
    fork
      begin
        automatic int w = t_stop;
        #(w) stop_in = 1'b1;
        #(4 * T) stop_in = 1'b0;
      end
    join_none
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_meas(input int tstop, input int maxc);
    int j, frac, ek, ej, s0_inc, s0_dec, s0_start, waited;
    logic eovf, sat;
    t_stop = tstop;
    max_coarse = CW'(maxc);
    s0_inc = n_inc; s0_dec = n_dec; s0_start = n_start;
    @(negedge clk) meas_req = 1'b1;
    @(negedge clk) meas_req = 1'b0;
    chk(result_valid == 1'b0, "R8 valid drops on accept", int'(result_valid), 0);
    waited = 0;
    while (!result_valid && waited < 40000) begin
      @(negedge clk);
      waited++;
    end
    chk(result_valid == 1'b1, "R6 watchdog: result never valid", int'(result_valid), 1);
    j = tstop / T;
    frac = tstop % T;
    eovf = j > maxc;
    sat = 1'b0;
    if (eovf) begin
      ej = maxc; ek = 0;
    end else begin
      ej = j; ek = 1;
      while (ek < STEPS - 1 && !(PH0 + ek * DT > frac)) ek++;
      sat = !(PH0 + ek * DT > frac);
    end
    chk(overflow == eovf, "R7 overflow flag", int'(overflow), int'(eovf));
    chk(int'(coarse_j) == ej, "R1 coarse J", int'(coarse_j), ej);
    if (sat) chk(int'(fine_k) == ek, "R5 saturated K", int'(fine_k), ek);
    else     chk(int'(fine_k) == ek, "R4 fine K", int'(fine_k), ek);
    chk(n_inc - s0_inc == ek, "R3 increment strobes", n_inc - s0_inc, ek);
    chk(n_dec - s0_dec == ek, "R6 decrement strobes", n_dec - s0_dec, ek);
    chk(ph_steps == 0, "R6 phase back at zero", ph_steps, 0);
    chk(n_start - s0_start == (eovf ? 1 : ek + 1), "R2 START count",
        n_start - s0_start, eovf ? 1 : ek + 1);
    repeat (40) @(negedge clk);
    chk(result_valid == 1'b1, "R8 valid held while idle", int'(result_valid), 1);
  endtask

  function automatic int clean(input int j, input int f);
    int ff = f;
    if ((ff - PH0) % DT == 0) ff += 5;
    return j * T + ff;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    chk(start_pulse == 1'b0, "R9 start low in reset", int'(start_pulse), 0);
    chk(ps_en == 1'b0, "R9 strobe low in reset", int'(ps_en), 0);
    chk(result_valid == 1'b0, "R9 valid low in reset", int'(result_valid), 0);
    chk(overflow == 1'b0, "R9 overflow low in reset", int'(overflow), 0);
    chk(busy == 1'b0, "R9 busy low in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_meas(clean(3, 5000), 6);    // R4 mid-period
    run_meas(clean(0, 40), 6);      // R1 J zero, R4 K=1
    run_meas(clean(6, 12345), 6);   // R1 J at the limit
    run_meas(clean(7, 3000), 6);    // R7 one above the limit
    run_meas(1 * T + 19950, 6);     // R5 saturation
    run_meas(clean(3, 800), 2);     // R7 small limit
    run_meas(clean(0, 9000), 0);    // R1 zero limit, no overflow
    for (int i = 0; i < 8; i++) begin
      run_meas(clean(i % 5, 500 + i * 2437), 6);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(64'd190000 * T);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule